// File: doc/BRIEF.md
# Tile Pattern Fetch Transformer

This block sits in the path between a tile-graphics memory and a video processor. The processor fetches 8x8 tiles one row at a time, each row as two separate bitplane bytes. The block changes how the processor's 13-bit pattern address reaches the memory and changes the byte that the memory returns. Four effects result, and each can be combined with the others: left-right mirroring, up-down mirroring, exchange of colour indices 1 and 2, and a leftward pixel shift that fills with transparent pixels. The memory contents never change. Every variant is produced at fetch time, so no second copy of the graphics is stored.

A CPU-side port writes two configuration registers. Both the address path and the data path are combinational, so no fetch latency is added. A small controller with two states decides when new settings reach the datapath. In state GAP no fetch is in progress, and the live settings follow the written registers. Transition START (GAP to BUSY) happens on the first cycle that `fetch_valid` is high. At that edge the settings are captured and then held. Transition END (BUSY to GAP) happens when `fetch_valid` goes low. A fetch therefore never sees a settings change part way through.

Top module: `tile_fetch_xform`

## Requirements
- R1: After reset, all modes are off and the shift is 0. `mem_addr` then equals `vid_addr` and `vid_data` equals `mem_data`.
- R2: With horizontal mirroring on, `vid_data` is the bit reverse of the byte read, so bit 7 (the leftmost pixel) and bit 0 (the rightmost pixel) trade places.
- R3: With vertical mirroring on, the row lines `mem_addr[2:0]` are the bitwise inverse of `vid_addr[2:0]`, so row r reads memory row 7-r.
- R4: With colour swap on, the bitplane line `mem_addr[3]` is the inverse of `vid_addr[3]`, so a plane-0 fetch reads plane 1 and a plane-1 fetch reads plane 0.
- R5: A shift of n (0 to 7) moves the data n bits toward bit 7 and fills the n low bits with zeros. The same shift applies to plane-0 and plane-1 fetches.
- R6: All modes work together, and horizontal mirroring is applied before the shift.
- R7: Register select 0 holds bit 0 = horizontal mirror, bit 1 = vertical mirror and bit 2 = colour swap. Register select 1 holds the shift in bits 2:0. A write applies to any fetch whose first `fetch_valid` cycle comes after the write's clock edge.
- R8: A write made while `fetch_valid` is high has no effect on the fetch in progress. It applies from the next fetch on.
- R9: The pattern table select and tile index bits `mem_addr[12:4]` always equal `vid_addr[12:4]`.
- R10: Both paths are combinational. `mem_addr` and `vid_data` reflect the current inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 for the mode flags, 1 for the shift |
| cfg_wdata | input | 8 | Configuration write data |
| fetch_valid | input | 1 | High while the processor performs a fetch |
| vid_addr | input | 13 | Pattern address from the video processor |
| vid_data | output | 8 | Transformed byte returned to the processor |
| mem_addr | output | 13 | Remapped address sent to the pattern memory |
| mem_data | input | 8 | Byte read from the pattern memory |

## Verification
The bench builds the block with its default parameters: a 13-bit address, three row lines and 8-pixel bytes. With these values every shift amount from 0 to 7 can be tried on both bitplanes, and every mode combination can be tried as well. The bench's memory model returns bytes that depend on the row, plane and tile bits. A wrong remapping therefore shows up as a data mismatch as well as an address mismatch. Writes are issued both between fetches and in the middle of a fetch, which exercises the START capture and the BUSY hold.

// File: rtl/tile_xform_pkg.sv
package tile_xform_pkg;
    localparam int SHIFT_W = 3;

    typedef struct packed {
        logic               hmir;
        logic               vmir;
        logic               swap;
        logic [SHIFT_W-1:0] shift;
    } xform_cfg_t;

    typedef enum logic {
        ST_GAP  = 1'b0,
        ST_BUSY = 1'b1
    } fetch_state_t;
endpackage

// File: rtl/tile_xform_ctrl.sv
module tile_xform_ctrl
    import tile_xform_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             fetch_valid,
    output xform_cfg_t       eff_cfg
);
    fetch_state_t state_q, state_d;
    xform_cfg_t   staged_q, held_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_GAP;
        else        state_q <= state_d;
    end

    // Transitions START and END
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GAP:  if (fetch_valid)  state_d = ST_BUSY;
            ST_BUSY: if (!fetch_valid) state_d = ST_GAP;
            default: state_d = ST_GAP;
        endcase
    end

    // Staged registers and capture at START
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q <= '0;
            held_q   <= '0;
        end else begin
            if (state_q == ST_GAP && fetch_valid) held_q <= staged_q;
            if (cfg_we) begin
                if (!cfg_sel) begin
                    staged_q.hmir <= cfg_wdata[0];
                    staged_q.vmir <= cfg_wdata[1];
                    staged_q.swap <= cfg_wdata[2];
                end else begin
                    staged_q.shift <= cfg_wdata[SHIFT_W-1:0];
                end
            end
        end
    end

    // Output process
    always_comb begin
        unique case (state_q)
            ST_GAP:  eff_cfg = staged_q;
            ST_BUSY: eff_cfg = held_q;
            default: eff_cfg = staged_q;
        endcase
    end

    // R8: settings stay frozen while a fetch continues
    a_r8_frozen_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && $past(fetch_valid)) |-> $stable(eff_cfg));
    // R1: reset clears all settings
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) |-> (eff_cfg == '0));
endmodule

// File: rtl/tile_xform_addr.sv
module tile_xform_addr
    import tile_xform_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int ROW_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xform_cfg_t        cfg,
    input  logic [ADDR_W-1:0] in_addr,
    output logic [ADDR_W-1:0] out_addr
);
    localparam int PLANE_BIT = ROW_W;
    localparam int TILE_LO   = ROW_W + 1;
    localparam logic [ROW_W-1:0] ROW_MAX = '1;

    always_comb begin
        out_addr[ADDR_W-1:TILE_LO] = in_addr[ADDR_W-1:TILE_LO];
        out_addr[PLANE_BIT]        = in_addr[PLANE_BIT] ^ cfg.swap;
        out_addr[ROW_W-1:0]        = cfg.vmir ? ~in_addr[ROW_W-1:0] : in_addr[ROW_W-1:0];
    end

    // R3: mirrored row and source row add up to the last row
    a_r3_row_sum: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.vmir |-> (ROW_W'(out_addr[ROW_W-1:0] + in_addr[ROW_W-1:0]) == ROW_MAX));
    // R4: swap flips the plane; otherwise the address differs only in row bits
    a_r4_plane_flip: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.swap |-> $countones(out_addr[ADDR_W-1:PLANE_BIT] ^ in_addr[ADDR_W-1:PLANE_BIT]) == 1);
    // R1: no modes means identity address
    a_r1_addr_ident: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.swap && !cfg.vmir) |-> (out_addr == in_addr));
endmodule

// File: rtl/tile_xform_data.sv
module tile_xform_data
    import tile_xform_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xform_cfg_t        cfg,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] out_data
);
    logic [DATA_W-1:0] reversed;
    logic [DATA_W-1:0] mirrored;

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign reversed[i] = in_data[DATA_W-1-i];
    end

    always_comb begin
        mirrored = cfg.hmir ? reversed : in_data;
        out_data = mirrored << cfg.shift;
    end

    // R5: vacated low pixels are transparent
    a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (out_data & ~({DATA_W{1'b1}} << cfg.shift)) == '0);
    // R2: mirroring alone keeps the pixel count
    a_r2_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.shift == '0) |-> ($countones(out_data) == $countones(in_data)));
endmodule

// File: rtl/tile_fetch_xform.sv
module tile_fetch_xform
    import tile_xform_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int ROW_W  = 3,
    parameter int DATA_W = 8,
    parameter int CFG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] vid_addr,
    output logic [DATA_W-1:0] vid_data,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data
);
    localparam int TILE_LO = ROW_W + 1;

    xform_cfg_t eff_cfg;

    tile_xform_ctrl #(.CFG_W(CFG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .fetch_valid(fetch_valid), .eff_cfg(eff_cfg)
    );

    tile_xform_addr #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .cfg(eff_cfg),
        .in_addr(vid_addr), .out_addr(mem_addr)
    );

    tile_xform_data #(.DATA_W(DATA_W)) u_data (
        .clk(clk), .rst_n(rst_n), .cfg(eff_cfg),
        .in_data(mem_data), .out_data(vid_data)
    );

    // R9: tile and table bits pass straight through at the ports
    a_r9_tile_kept: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[ADDR_W-1:TILE_LO] == vid_addr[ADDR_W-1:TILE_LO]);
endmodule

// File: tb/tile_fetch_xform_bench.sv
module tile_fetch_xform_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0, fetch_valid = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [12:0] vid_addr = '0;
    logic [7:0]  vid_data, mem_data;
    logic [12:0] mem_addr;

    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    tile_fetch_xform u_tile_fetch_xform (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .fetch_valid(fetch_valid), .vid_addr(vid_addr),
        .vid_data(vid_data), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    function automatic logic [7:0] memf(input logic [12:0] a);
        return (a[7:0] * 8'd37) ^ {3'b000, a[12:8]};
    endfunction

    assign mem_data = memf(mem_addr);

    typedef struct {
        logic [12:0] addr;
        logic [7:0]  data;
        string       tag;
    } exp_t;
    exp_t q[$];

    // bench model of settings, built from R7/R8
    logic       m_busy = 0;
    logic [5:0] m_staged = '0, m_held = '0; // {hmir,vmir,swap,shift[2:0]}

    task automatic step(input logic we, input logic sel, input logic [7:0] wd,
                        input logic fv, input logic [12:0] a, input string tag);
        logic [5:0]  e;
        logic [12:0] ea;
        logic [7:0]  d, r;
        @(posedge clk); #1;
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd; fetch_valid = fv; vid_addr = a;
        e  = m_busy ? m_held : m_staged;
        ea = {a[12:4], a[3] ^ e[3], e[4] ? ~a[2:0] : a[2:0]};
        d  = memf(ea);
        for (int i = 0; i < 8; i++) r[i] = d[7-i];
        if (e[5]) d = r;
        d = d << e[2:0];
        q.push_back('{ea, d, tag});
        if (!m_busy && fv) m_held = m_staged;
        if (we) begin
            if (!sel) m_staged[5:3] = {wd[0], wd[1], wd[2]};
            else      m_staged[2:0] = wd[2:0];
        end
        m_busy = fv;
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            checks++;
            if (mem_addr !== x.addr || vid_data !== x.data) begin
                failures++;
                $display("FAIL %s: addr=%h data=%h expected addr=%h data=%h",
                         x.tag, mem_addr, vid_data, x.addr, x.data);
            end
        end
    end

    task automatic wr(input logic sel, input logic [7:0] v);
        step(1'b1, sel, v, 1'b0, 13'h0000, "R7 write cycle");
    endtask

    // one fetch: both planes of a row, then an idle cycle
    task automatic fetch_row(input logic [12:0] base, input string tag);
        step(0, 0, 0, 1'b1, base & ~13'h0008, tag);
        step(0, 0, 0, 1'b1, base | 13'h0008, tag);
        step(0, 0, 0, 1'b0, base, tag);
    endtask

    bit done = 0;
    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 / R10: pass-through after reset, same-cycle response
        fetch_row(13'h1A35, "R1 reset passthrough");
        fetch_row(13'h0042, "R10 combinational");
        // R2
        wr(0, 8'h01);
        fetch_row(13'h0123, "R2 hmirror");
        fetch_row(13'h1FF7, "R2 hmirror");
        // R3
        wr(0, 8'h02);
        for (int r = 0; r < 8; r++) fetch_row(13'h0560 | 13'(r), "R3 vmirror");
        // R4 / R9
        wr(0, 8'h04);
        fetch_row(13'h0AB2, "R4 swap");
        fetch_row(13'h1F0D, "R9 tile bits");
        // R5: every shift, both planes
        wr(0, 8'h00);
        for (int s = 0; s < 8; s++) begin
            wr(1, 8'(s));
            fetch_row(13'h0ED4, "R5 shift");
        end
        // R6 combined
        wr(0, 8'h07);
        wr(1, 8'h03);
        fetch_row(13'h0771, "R6 all modes");
        fetch_row(13'h1236, "R6 all modes");
        // R7: write then fetch on the very next cycle
        wr(1, 8'h05);
        step(0, 0, 0, 1'b1, 13'h0333, "R7 next-cycle fetch");
        step(0, 0, 0, 1'b0, 13'h0333, "R7 gap");
        // R8: write in the middle of a fetch
        step(0, 0, 0, 1'b1, 13'h0444, "R8 fetch start");
        step(1, 0, 8'h00, 1'b1, 13'h044C, "R8 write mid-fetch");
        step(1, 1, 8'h00, 1'b1, 13'h0445, "R8 still old");
        step(0, 0, 0, 1'b1, 13'h044D, "R8 still old");
        step(0, 0, 0, 1'b0, 13'h0444, "R8 gap");
        fetch_row(13'h0444, "R8 next fetch new");
        // reset again: R1
        @(posedge clk); #1 rst_n = 1'b0; fetch_valid = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        m_busy = 0; m_staged = '0; m_held = '0;
        fetch_row(13'h1555, "R1 after second reset");
        repeat (3) @(posedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule